// File: doc/BRIEF.md
# Link-On Wake Signal Controller

This block sits in a serial-bus physical layer and raises a wake indication toward a link-layer controller that has gone to sleep. While a wake request is outstanding it drives a square wave of eight system-clock cycles per period onto a single pad. When no request is outstanding it drives the pad low. During hardware reset it releases the pad to high impedance so that a strap resistor on the same pin can be sampled.

A wake request can come from two kinds of source. The first is a one-cycle pulse for a received link-on packet addressed to this node. This pulse is held in a sticky latch. The second is a set of interrupt bits, which are evaluated every cycle. The port-event bit is enough on its own. The configuration-timeout, cable-power-status and state-timeout bits count only while the resuming-port interrupt enable is set.

A request is honoured only while the link is idle. The link is idle when its power status is low or its control bit is clear. The request is withdrawn once both of those are high. A bus reset cancels a request that rests only on the packet latch. A request backed by an interrupt survives the bus reset, and the wave continues without restarting its phase. All control inputs are synchronous to `clk`. The square wave is the only output function; no data stream passes through the block, so no valid/ready interface is used.

Top module: `linkon_wake`

## Requirements
- R1: While `rst_n` is low, `wake_oe` is 0, `wake_out` is 0 and `wake_pad` is high impedance. From the first rising edge after reset is released, `wake_oe` is 1 and `wake_pad` follows `wake_out`.
- R2: While a request is active, `wake_out` repeats a period of 8 cycles. It is high for the 4 cycles starting at the edge where the request becomes active, then low for 4 cycles.
- R3: While no request is active, `wake_out` is driven low with `wake_oe` at 1.
- R4: The link counts as up when `link_power_on` and `link_ctrl_en` are both 1. While the link is up, no source activates the output and a `pkt_linkon` pulse is ignored: it leaves no latched request behind.
- R5: A `pkt_linkon` pulse while the link is idle starts the wave at the next edge. The request stays latched after the pulse ends.
- R6: `int_port_evt` = 1 with the link idle activates the output whatever the value of `resume_int_en`.
- R7: `int_cfg_tmo`, `int_cbl_pwr` or `int_state_tmo` activates the output only while `resume_int_en` = 1.
- R8: When the link comes up, `wake_out` is low from the next rising edge on.
- R9: A `bus_reset` pulse clears a packet-only request, so `wake_out` is low from the next edge. If a qualifying interrupt still holds, the wave continues with its phase unchanged.
- R10: An interrupt that qualifies while the link is up starts the wave at the first edge after the link goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous assert |
| link_power_on | input | 1 | Link power status, 1 = powered |
| link_ctrl_en | input | 1 | Link control enable bit |
| pkt_linkon | input | 1 | One-cycle pulse: link-on packet for this node received |
| int_port_evt | input | 1 | Port-event interrupt bit |
| int_cfg_tmo | input | 1 | Configuration-timeout interrupt bit |
| int_cbl_pwr | input | 1 | Cable-power-status interrupt bit |
| int_state_tmo | input | 1 | State-timeout interrupt bit |
| resume_int_en | input | 1 | Resuming-port interrupt enable |
| bus_reset | input | 1 | One-cycle pulse: bus reset event |
| wake_out | output | 1 | Wake square wave, low when idle |
| wake_oe | output | 1 | Pad output enable, 0 during reset |
| wake_pad | output | 1 | Pad value: `wake_out` when enabled, else high impedance |

## Verification
The assertions assume that every control input changes only between clock edges. They also assume that `pkt_linkon` and `bus_reset` are single-cycle pulses, and that the interrupt bits are held steady levels rather than glitches. The bench drives every input a few nanoseconds after a rising edge and holds it across the next edge. It raises each pulse input for exactly one cycle, which keeps the stimulus within those assumptions. The bench covers all link states against all interrupt and enable combinations, checks the wave across several full periods, and exercises bus reset with and without a pending interrupt.

// File: rtl/linkon_pkg.sv
package linkon_pkg;

  localparam int unsigned DEF_HALF_CYCLES = 4;

  typedef struct packed {
    logic port_evt;
    logic cfg_tmo;
    logic cbl_pwr;
    logic state_tmo;
  } irq_bits_t;

  // Interrupt part of the wake request: the port event alone, or any
  // resume-class bit when the resume enable is set.
  function automatic logic irq_qualifies(irq_bits_t b, logic resume_en);
    return b.port_evt | (resume_en & (b.cfg_tmo | b.cbl_pwr | b.state_tmo));
  endfunction

endpackage

// File: rtl/linkon_req.sv
module linkon_req
  import linkon_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      link_power_on,
  input  logic      link_ctrl_en,
  input  logic      pkt_linkon,
  input  irq_bits_t irq,
  input  logic      resume_int_en,
  input  logic      bus_reset,
  output logic      req_next
);

  logic link_up;
  logic pkt_q;
  logic pkt_live;
  logic irq_live;

  assign link_up = link_power_on & link_ctrl_en;

  // Sticky packet request: cleared by link-up or bus reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pkt_q <= 1'b0;
    else if (link_up || bus_reset) pkt_q <= 1'b0;
    else if (pkt_linkon)         pkt_q <= 1'b1;
  end

  always_comb begin
    pkt_live = (pkt_q | pkt_linkon) & ~bus_reset;
    irq_live = irq_qualifies(irq, resume_int_en);
    req_next = ~link_up & (pkt_live | irq_live);
  end

endmodule

// File: rtl/linkon_phase.sv
module linkon_phase #(
  parameter int unsigned HALF_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_next,
  output logic active_q,
  output logic wave,
  output logic oe
);

  localparam int unsigned PERIOD = 2 * HALF_CYCLES;
  localparam int unsigned CW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
  localparam logic [CW-1:0] HALF = CW'(HALF_CYCLES);

  logic [CW-1:0] phase_q;
  logic [CW-1:0] phase_inc;

  generate
    if ((PERIOD & (PERIOD - 1)) == 0) begin : g_pow2
      assign phase_inc = phase_q + 1'b1;
    end else begin : g_cmp
      assign phase_inc = (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= '0;
      oe       <= 1'b0;
    end else begin
      oe       <= 1'b1;
      active_q <= req_next;
      if (req_next && active_q) phase_q <= phase_inc;
      else                      phase_q <= '0;
    end
  end

  assign wave = active_q & (phase_q < HALF);

endmodule

// File: rtl/linkon_wake.sv
module linkon_wake
  import linkon_pkg::*;
#(
  parameter int unsigned HALF_CYCLES = DEF_HALF_CYCLES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_power_on,
  input  logic link_ctrl_en,
  input  logic pkt_linkon,
  input  logic int_port_evt,
  input  logic int_cfg_tmo,
  input  logic int_cbl_pwr,
  input  logic int_state_tmo,
  input  logic resume_int_en,
  input  logic bus_reset,
  output logic wake_out,
  output logic wake_oe,
  output wire  wake_pad
);

  irq_bits_t irq;
  logic      req_next;
  logic      active_r;
  logic      wave;

  assign irq = '{port_evt: int_port_evt, cfg_tmo: int_cfg_tmo,
                 cbl_pwr: int_cbl_pwr, state_tmo: int_state_tmo};

  linkon_req u_req (
    .clk           (clk),
    .rst_n         (rst_n),
    .link_power_on (link_power_on),
    .link_ctrl_en  (link_ctrl_en),
    .pkt_linkon    (pkt_linkon),
    .irq           (irq),
    .resume_int_en (resume_int_en),
    .bus_reset     (bus_reset),
    .req_next      (req_next)
  );

  linkon_phase #(.HALF_CYCLES(HALF_CYCLES)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_next (req_next),
    .active_q (active_r),
    .wave     (wave),
    .oe       (wake_oe)
  );

  assign wake_out = wave & wake_oe;
  assign wake_pad = wake_oe ? wake_out : 1'bz;

endmodule

// File: rtl/linkon_wake_chk.sv
module linkon_wake_chk (
  input logic clk,
  input logic rst_n,
  input logic link_power_on,
  input logic link_ctrl_en,
  input logic int_port_evt,
  input logic int_cfg_tmo,
  input logic int_cbl_pwr,
  input logic int_state_tmo,
  input logic resume_int_en,
  input logic pkt_linkon,
  input logic bus_reset,
  input logic active,
  input logic wake_out,
  input logic wake_oe
);

  logic up, irq_ok;
  assign up     = link_power_on & link_ctrl_en;
  assign irq_ok = int_port_evt |
                  (resume_int_en & (int_cfg_tmo | int_cbl_pwr | int_state_tmo));

  // R8
  link_up_silences_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up |=> !wake_out);

  // R6
  irq_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!up && irq_ok) |=> active);

  // R9
  bus_reset_drops_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && !irq_ok) |=> !active);

  // R2
  first_half_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> wake_out);

  // R1
  oe_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> wake_oe);

  // R5
  pkt_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!up && pkt_linkon && !bus_reset) |=> active);

endmodule

bind linkon_wake linkon_wake_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .link_power_on (link_power_on),
  .link_ctrl_en  (link_ctrl_en),
  .int_port_evt  (int_port_evt),
  .int_cfg_tmo   (int_cfg_tmo),
  .int_cbl_pwr   (int_cbl_pwr),
  .int_state_tmo (int_state_tmo),
  .resume_int_en (resume_int_en),
  .pkt_linkon    (pkt_linkon),
  .bus_reset     (bus_reset),
  .active        (active_r),
  .wake_out      (wake_out),
  .wake_oe       (wake_oe)
);

// File: tb/tb_linkon_wake.sv
`timescale 1ns/1ps
module tb_linkon_wake;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_power_on = 1'b1, link_ctrl_en = 1'b1;
  logic pkt_linkon = 1'b0, bus_reset = 1'b0;
  logic int_port_evt = 1'b0, int_cfg_tmo = 1'b0, int_cbl_pwr = 1'b0, int_state_tmo = 1'b0;
  logic resume_int_en = 1'b0;
  logic wake_out, wake_oe;
  wire  wake_pad;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  linkon_wake dut (.*);

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #5;
  endtask

  task automatic clear_all();
    {int_port_evt, int_cfg_tmo, int_cbl_pwr, int_state_tmo, resume_int_en} = '0;
    pkt_linkon = 0; bus_reset = 0;
    link_power_on = 1; link_ctrl_en = 1;
    step();
  endtask

  task automatic link_idle();
    link_power_on = 0; link_ctrl_en = 1;
  endtask

  initial begin
    // R1: reset state, even with a request present
    int_port_evt = 1; link_power_on = 0;
    #5;
    repeat (3) begin
      chk(wake_oe, 1'b0, "R1 oe in reset");
      chk(wake_pad === 1'bz, 1'b1, "R1 pad hiZ");
      chk(wake_out, 1'b0, "R1 out in reset");
      @(negedge clk);
    end
    int_port_evt = 0; link_power_on = 1;
    #3 rst_n = 1;
    step();
    chk(wake_oe, 1'b1, "R1 oe after reset");
    chk(wake_out, 1'b0, "R3 idle low");
    chk(wake_pad, 1'b0, "R1 pad follows");

    // R4 R6 R7: every link state against every interrupt/enable combination
    for (int ls = 0; ls < 4; ls++) begin
      for (int v = 0; v < 32; v++) begin
        logic exp;
        link_power_on = ls[0]; link_ctrl_en = ls[1];
        int_port_evt = v[0]; int_cfg_tmo = v[1]; int_cbl_pwr = v[2];
        int_state_tmo = v[3]; resume_int_en = v[4];
        exp = !(ls[0] && ls[1]) && (v[0] || (v[4] && (v[1] || v[2] || v[3])));
        step();
        chk(wake_out, exp, "R4/R6/R7 sweep");
        clear_all();
        chk(wake_out, 1'b0, "R3 low after clear");
      end
    end

    // R2: period of 8, 4 high then 4 low, over three periods
    link_idle(); int_port_evt = 1;
    for (int k = 0; k < 24; k++) begin
      step();
      chk(wake_out, (k % 8) < 4, "R2 wave");
      chk(wake_pad, (k % 8) < 4, "R1 pad wave");
    end
    // R8: link up -> low from next edge
    link_power_on = 1; link_ctrl_en = 1;
    step();
    chk(wake_out, 1'b0, "R8 off after link up");
    step();
    chk(wake_out, 1'b0, "R8 stays off");
    clear_all();

    // R5: packet pulse latches
    link_idle();
    pkt_linkon = 1; step(); pkt_linkon = 0;
    chk(wake_out, 1'b1, "R5 start");
    for (int k = 1; k < 12; k++) begin
      step();
      chk(wake_out, (k % 8) < 4, "R5 latched wave");
    end
    // R9: bus reset drops packet-only request
    bus_reset = 1; step(); bus_reset = 0;
    chk(wake_out, 1'b0, "R9 packet cleared");
    repeat (8) begin step(); chk(wake_out, 1'b0, "R9 stays cleared"); end
    clear_all();

    // R4: packet while link up leaves nothing latched
    pkt_linkon = 1; step(); pkt_linkon = 0;
    chk(wake_out, 1'b0, "R4 pkt ignored while up");
    link_idle(); step();
    chk(wake_out, 1'b0, "R4 no latched pkt");
    clear_all();

    // R9: interrupt-backed request survives bus reset with phase intact
    link_idle(); int_state_tmo = 1; resume_int_en = 1; pkt_linkon = 1;
    step(); pkt_linkon = 0;
    for (int k = 1; k < 16; k++) begin
      bus_reset = (k == 6);
      step();
      chk(wake_out, (k % 8) < 4, "R9 irq survives bus reset");
    end
    bus_reset = 0;
    int_state_tmo = 0; step();
    chk(wake_out, 1'b0, "R9 packet gone after irq drops");
    clear_all();

    // R10: pending interrupt while link up, fires when link goes idle
    int_cbl_pwr = 1; resume_int_en = 1;
    repeat (3) begin step(); chk(wake_out, 1'b0, "R10 held while up"); end
    link_ctrl_en = 0;
    step();
    chk(wake_out, 1'b1, "R10 fires on idle");
    step();
    chk(wake_out, 1'b1, "R10 wave continues");
    // R7: dropping the enable withdraws the request
    resume_int_en = 0; step();
    chk(wake_out, 1'b0, "R7 enable gates");
    clear_all();

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule